// File: doc/BRIEF.md
# Sonar Echo Ranging Controller

This block is the digital core of a single-beam depth sounder. It has a power state and a display-unit state, each changed by a pushbutton. While powered, it repeats a ping cycle. It waits a fixed interval, enables an external transmitter for a fixed number of carrier periods, and then listens for an echo. The time from the start of the burst to the echo is counted directly in BCD. A foot-rate enable pulse stands for one foot of depth, so the count is the depth with no conversion step. The digits are shown on common-anode seven-segment displays.

In meters mode a fractional accumulator scales the foot pulses before they reach the BCD counter, so the latched value is in meters. The transmitter timing comes from a separate carrier-rate enable. The echo input is an asynchronous logic level. It is synchronized inside the block and ignored while the transmitter is on. If no echo arrives within the receive window, the block raises an error flag and shows dashes until a good reading arrives.

Top module: `sonar_ranger`

## Requirements
- R1: After reset the block is powered off. While off, `tx_en` is 0, `err` is 0, every `seg_n` bit is 1 (dark) and both unit LEDs are 1 (dark). A units press while off has no effect.
- R2: A press is a rising edge on a button input. A power press while off powers the block up into the idle phase and shows 000 with `err` low. A power press in any powered phase (idle, send or receive) goes back to off.
- R3: A units press in a powered phase toggles between feet and meters without changing the phase. `led_feet_n` is 0 in feet mode and `led_meters_n` is 0 in meters mode. Reset selects feet, and the mode is kept across power off.
- R4: The idle phase lasts exactly IDLE_TICKS foot pulses. The next foot pulse after that count raises `tx_en` and starts the send phase.
- R5: `tx_en` stays high for exactly BURST_CYCLES carrier pulses. On the last of these pulses the block enters the receive phase.
- R6: The block counts the foot pulses seen since the send phase began. When the synchronized echo is high in the receive phase, it latches the count to the display and returns to idle. Display encoding: digit d (d=0 for ones) uses `seg_n[7d+6:7d]`, with bit 0..6 = segments a..g. A segment is lit when its bit is 0. The lit segments are: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=all, 9=abcdfg.
- R7: In meters mode the latched value is floor(N·METER_NUM/METER_DEN), where N is the number of foot pulses. By default this is one meter per 3.281 feet.
- R8: The echo level is ignored during the send phase. It neither shortens the burst nor changes the reading.
- R9: If RECV_TICKS foot pulses pass in the receive phase with no echo, `err` rises. Every digit then shows only segment g (a dash), and the block returns to idle. The next good echo clears `err`.
- R10: The displayed value does not change between echoes, through the idle and send phases.
- R11: The BCD count saturates at all nines (999) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_btn | input | 1 | Debounced power pushbutton, high while pressed |
| units_btn | input | 1 | Debounced feet/meters pushbutton, high while pressed |
| echo_in | input | 1 | Asynchronous echo-detect level from the receiver |
| foot_tick | input | 1 | One-cycle pulse per foot of round-trip time |
| carrier_tick | input | 1 | One-cycle pulse per transmit carrier period |
| tx_en | output | 1 | Transmitter burst enable |
| seg_n | output | 21 (DIGITS×7) | Active-low segment cathodes, ones digit in the low bits |
| led_feet_n | output | 1 | Active-low feet indicator |
| led_meters_n | output | 1 | Active-low meters indicator |
| err | output | 1 | No-echo error flag |

## Verification
The bench builds the block with IDLE_TICKS=8 and RECV_TICKS=1005, and keeps the 16-pulse burst and the 1000/3281 meter ratio. The short idle interval lets many pings run back to back. A receive window just past 999 lets a single ping reach BCD saturation and, separately, the no-echo timeout, each within a few thousand cycles. Meter readings are chosen to sit on both sides of whole-meter boundaries, so the accumulator's rounding is checked.

// File: rtl/sonar_pkg.sv
package sonar_pkg;

   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_IDLE = 2'd1,
      ST_SEND = 2'd2,
      ST_RECV = 2'd3
   } rng_state_e;

   // Active-high segment pattern, bit 0 = a ... bit 6 = g
   localparam logic [6:0] SEG_DASH = 7'b100_0000;

   function automatic logic [6:0] seg_of(input logic [3:0] d);
      logic [6:0] p;
      case (d)
         4'd0: p = 7'b011_1111;
         4'd1: p = 7'b000_0110;
         4'd2: p = 7'b101_1011;
         4'd3: p = 7'b100_1111;
         4'd4: p = 7'b110_0110;
         4'd5: p = 7'b110_1101;
         4'd6: p = 7'b111_1101;
         4'd7: p = 7'b000_0111;
         4'd8: p = 7'b111_1111;
         4'd9: p = 7'b110_1111;
         default: p = 7'b000_0000;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/echo_sync.sv
module echo_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("echo_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain #(
   parameter int DIGITS = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  inc,
   output logic [DIGITS*4-1:0]   value
);
   if (DIGITS < 1) begin : g_bad_digits
      $error("bcd_chain: DIGITS must be at least 1");
   end

   logic [DIGITS-1:0] nine;
   logic [DIGITS:0]   carry;
   logic              full;

   assign full     = &nine;
   assign carry[0] = inc & ~full;

   for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      logic [3:0] d_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          d_q <= '0;
         else if (clr)        d_q <= '0;
         else if (carry[i])   d_q <= nine[i] ? 4'd0 : d_q + 4'd1;
      end

      assign nine[i]        = (d_q == 4'd9);
      assign carry[i+1]     = carry[i] & nine[i];
      assign value[i*4 +: 4] = d_q;
   end
endmodule

// File: rtl/meter_scaler.sv
module meter_scaler #(
   parameter int NUM = 1000,
   parameter int DEN = 3281
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic meters,
   output logic step
);
   if (NUM < 1 || NUM > DEN) begin : g_bad_ratio
      $error("meter_scaler: need 1 <= NUM <= DEN");
   end

   localparam int AW = $clog2(NUM + DEN + 1);
   localparam logic [AW-1:0] NUM_W = AW'(NUM);
   localparam logic [AW-1:0] DEN_W = AW'(DEN);

   logic [AW-1:0] acc_q;
   logic [AW-1:0] sum;
   logic          reach;

   assign sum   = acc_q + NUM_W;
   assign reach = (sum >= DEN_W);

   if (NUM == DEN) begin : g_unity
      assign step = tick;
   end else begin : g_frac
      assign step = tick & (meters ? reach : 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                acc_q <= '0;
      else if (clr)              acc_q <= '0;
      else if (tick && meters)   acc_q <= reach ? sum - DEN_W : sum;
   end
endmodule

// File: rtl/seg7_digit.sv
module seg7_digit
   import sonar_pkg::*;
(
   input  logic [3:0] digit,
   input  logic       blank,
   input  logic       dash,
   output logic [6:0] seg_n
);
   always_comb begin
      if (blank)     seg_n = 7'h7F;
      else if (dash) seg_n = ~SEG_DASH;
      else           seg_n = ~seg_of(digit);
   end
endmodule

// File: rtl/ranger_fsm.sv
module ranger_fsm
   import sonar_pkg::*;
#(
   parameter int IDLE_TICKS   = 250,
   parameter int BURST_CYCLES = 16,
   parameter int RECV_TICKS   = 60
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_press,
   input  logic       units_press,
   input  logic       foot_tick,
   input  logic       carrier_tick,
   input  logic       echo,
   output rng_state_e state,
   output logic       meters,
   output logic       start_ping,
   output logic       meas_tick,
   output logic       echo_hit,
   output logic       rx_expire,
   output logic       wake,
   output logic       sleep
);
   if (IDLE_TICKS < 1 || BURST_CYCLES < 1 || RECV_TICKS < 1) begin : g_bad_cnt
      $error("ranger_fsm: interval parameters must be at least 1");
   end

   localparam int MAX_A = (IDLE_TICKS > BURST_CYCLES) ? IDLE_TICKS : BURST_CYCLES;
   localparam int MAX_V = (MAX_A > RECV_TICKS) ? MAX_A : RECV_TICKS;
   localparam int CW    = $clog2(MAX_V + 1);
   localparam logic [CW-1:0] IDLE_LAST  = CW'(IDLE_TICKS - 1);
   localparam logic [CW-1:0] BURST_LAST = CW'(BURST_CYCLES - 1);
   localparam logic [CW-1:0] RECV_LAST  = CW'(RECV_TICKS - 1);

   rng_state_e    st_q, st_d;
   logic [CW-1:0] ph_q, ph_d;
   logic          mode_q;

   always_comb begin
      st_d       = st_q;
      ph_d       = ph_q;
      start_ping = 1'b0;
      echo_hit   = 1'b0;
      rx_expire  = 1'b0;
      wake       = 1'b0;
      sleep      = 1'b0;
      case (st_q)
         ST_OFF: begin
            if (pwr_press) begin
               st_d = ST_IDLE;
               ph_d = '0;
               wake = 1'b1;
            end
         end
         ST_IDLE: begin
            if (pwr_press) begin
               st_d  = ST_OFF;
               ph_d  = '0;
               sleep = 1'b1;
            end else if (foot_tick) begin
               if (ph_q == IDLE_LAST) begin
                  st_d       = ST_SEND;
                  ph_d       = '0;
                  start_ping = 1'b1;
               end else begin
                  ph_d = ph_q + 1'b1;
               end
            end
         end
         ST_SEND: begin
            if (pwr_press) begin
               st_d  = ST_OFF;
               ph_d  = '0;
               sleep = 1'b1;
            end else if (carrier_tick) begin
               if (ph_q == BURST_LAST) begin
                  st_d = ST_RECV;
                  ph_d = '0;
               end else begin
                  ph_d = ph_q + 1'b1;
               end
            end
         end
         ST_RECV: begin
            if (pwr_press) begin
               st_d  = ST_OFF;
               ph_d  = '0;
               sleep = 1'b1;
            end else if (echo) begin
               st_d     = ST_IDLE;
               ph_d     = '0;
               echo_hit = 1'b1;
            end else if (foot_tick) begin
               if (ph_q == RECV_LAST) begin
                  st_d      = ST_IDLE;
                  ph_d      = '0;
                  rx_expire = 1'b1;
               end else begin
                  ph_d = ph_q + 1'b1;
               end
            end
         end
         default: begin
            st_d = ST_OFF;
            ph_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_OFF;
         ph_q   <= '0;
         mode_q <= 1'b0;
      end else begin
         st_q <= st_d;
         ph_q <= ph_d;
         if (units_press && st_q != ST_OFF) mode_q <= ~mode_q;
      end
   end

   assign state     = st_q;
   assign meters    = mode_q;
   assign meas_tick = foot_tick & ((st_q == ST_SEND) | (st_q == ST_RECV));
endmodule

// File: rtl/sonar_ranger.sv
module sonar_ranger
   import sonar_pkg::*;
#(
   parameter int DIGITS       = 3,
   parameter int IDLE_TICKS   = 250,
   parameter int BURST_CYCLES = 16,
   parameter int RECV_TICKS   = 60,
   parameter int METER_NUM    = 1000,
   parameter int METER_DEN    = 3281,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pwr_btn,
   input  logic                  units_btn,
   input  logic                  echo_in,
   input  logic                  foot_tick,
   input  logic                  carrier_tick,
   output logic                  tx_en,
   output logic [DIGITS*7-1:0]   seg_n,
   output logic                  led_feet_n,
   output logic                  led_meters_n,
   output logic                  err
);
   localparam int BW = DIGITS * 4;

   logic          pwr_q, units_q;
   logic          pwr_press, units_press;
   logic          echo_s;
   rng_state_e    st;
   logic          meters, start_ping, meas_tick, echo_hit, rx_expire, wake, sleep;
   logic          step;
   logic [BW-1:0] count;
   logic [BW-1:0] disp_q;
   logic          err_q;
   logic          powered;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q   <= 1'b0;
         units_q <= 1'b0;
      end else begin
         pwr_q   <= pwr_btn;
         units_q <= units_btn;
      end
   end

   assign pwr_press   = pwr_btn & ~pwr_q;
   assign units_press = units_btn & ~units_q;

   echo_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (echo_in),
      .q     (echo_s)
   );

   ranger_fsm #(
      .IDLE_TICKS   (IDLE_TICKS),
      .BURST_CYCLES (BURST_CYCLES),
      .RECV_TICKS   (RECV_TICKS)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .pwr_press    (pwr_press),
      .units_press  (units_press),
      .foot_tick    (foot_tick),
      .carrier_tick (carrier_tick),
      .echo         (echo_s),
      .state        (st),
      .meters       (meters),
      .start_ping   (start_ping),
      .meas_tick    (meas_tick),
      .echo_hit     (echo_hit),
      .rx_expire    (rx_expire),
      .wake         (wake),
      .sleep        (sleep)
   );

   meter_scaler #(.NUM(METER_NUM), .DEN(METER_DEN)) u_scale (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start_ping),
      .tick   (meas_tick),
      .meters (meters),
      .step   (step)
   );

   bcd_chain #(.DIGITS(DIGITS)) u_bcd (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_ping),
      .inc   (step),
      .value (count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_q <= '0;
         err_q  <= 1'b0;
      end else if (wake) begin
         disp_q <= '0;
         err_q  <= 1'b0;
      end else if (sleep) begin
         err_q  <= 1'b0;
      end else if (echo_hit) begin
         disp_q <= count;
         err_q  <= 1'b0;
      end else if (rx_expire) begin
         err_q  <= 1'b1;
      end
   end

   assign powered = (st != ST_OFF);

   for (genvar i = 0; i < DIGITS; i++) begin : g_seg
      seg7_digit u_dig (
         .digit (disp_q[i*4 +: 4]),
         .blank (~powered),
         .dash  (err_q),
         .seg_n (seg_n[i*7 +: 7])
      );
   end

   assign tx_en        = (st == ST_SEND);
   assign led_feet_n   = ~(powered & ~meters);
   assign led_meters_n = ~(powered & meters);
   assign err          = err_q;
endmodule

// File: rtl/sonar_ranger_chk.sv
module sonar_ranger_chk
   import sonar_pkg::*;
#(
   parameter int DIGITS = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                pwr_btn,
   input rng_state_e          state,
   input logic                tx_en,
   input logic [DIGITS*7-1:0] seg_n,
   input logic                led_feet_n,
   input logic                led_meters_n,
   input logic                err
);
   // R1: powered-off outputs are dark and quiet
   p_off_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OFF) |-> (&seg_n && led_feet_n && led_meters_n && !tx_en && !err));

   // R2: a power press while powered ends in off
   p_power_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwr_btn) && state != ST_OFF) |=> (state == ST_OFF));

   // R3: exactly one unit LED lit while powered
   p_one_led_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_OFF) |-> (led_feet_n != led_meters_n));

   // R4: a burst only begins out of the idle phase
   p_burst_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> ($past(state) == ST_IDLE));

   // R5: send is left only for receive or off
   p_send_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEND) |=> (state == ST_SEND || state == ST_RECV || state == ST_OFF));

   // R8: nothing seen during send alters the display
   p_send_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEND) |=> (state == ST_OFF || $stable(seg_n)));

   // R10: display holds through idle
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && $past(state) == ST_IDLE) |-> $stable(seg_n));

   // R9: error shows a dash on every digit
   for (genvar d = 0; d < DIGITS; d++) begin : g_dash
      p_err_dash_r9: assert property (@(posedge clk) disable iff (!rst_n)
         err |-> (seg_n[d*7 +: 7] == 7'b011_1111));
   end
endmodule

bind sonar_ranger sonar_ranger_chk #(.DIGITS(DIGITS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pwr_btn      (pwr_btn),
   .state        (st),
   .tx_en        (tx_en),
   .seg_n        (seg_n),
   .led_feet_n   (led_feet_n),
   .led_meters_n (led_meters_n),
   .err          (err)
);

// File: tb/sonar_ranger_test.sv
module sonar_ranger_test;
   localparam int IDLE  = 8;
   localparam int BURST = 16;
   localparam int RXT   = 1005;
   localparam int NV    = 6;
   // {meters mode, foot pulses, expected reading}
   localparam int VEC [NV][3] = '{
      '{0,  2,  2}, '{0, 50, 50}, '{1, 33, 10},
      '{1, 49, 14}, '{1,  4,  1}, '{0, 17, 17}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_btn = 1'b0, units_btn = 1'b0, echo_in = 1'b0;
   logic        foot_tick = 1'b0, carrier_tick = 1'b0;
   logic        tx_en, led_feet_n, led_meters_n, err;
   logic [20:0] seg_n;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   logic  [20:0] cur_disp;
   bit    cur_m = 1'b0;

   always #4 clk = ~clk;

   sonar_ranger #(
      .DIGITS(3), .IDLE_TICKS(IDLE), .BURST_CYCLES(BURST), .RECV_TICKS(RXT),
      .METER_NUM(1000), .METER_DEN(3281), .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .pwr_btn(pwr_btn), .units_btn(units_btn),
      .echo_in(echo_in), .foot_tick(foot_tick), .carrier_tick(carrier_tick),
      .tx_en(tx_en), .seg_n(seg_n), .led_feet_n(led_feet_n),
      .led_meters_n(led_meters_n), .err(err)
   );

   function automatic logic [6:0] pat(input int d);
      case (d)
         0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
         4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
         8: return 7'h7F; default: return 7'h6F;
      endcase
   endfunction

   function automatic logic [20:0] disp(input int v);
      return ~{pat((v / 100) % 10), pat((v / 10) % 10), pat(v % 10)};
   endfunction

   localparam logic [20:0] DASHES = {3{7'b011_1111}};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick_foot();
      @(negedge clk) foot_tick = 1'b1;
      @(negedge clk) foot_tick = 1'b0;
      wait_n(2);
   endtask

   task automatic tick_car();
      @(negedge clk) carrier_tick = 1'b1;
      @(negedge clk) carrier_tick = 1'b0;
      wait_n(2);
   endtask

   task automatic press_pwr();
      @(negedge clk) pwr_btn = 1'b1;
      wait_n(2);
      pwr_btn = 1'b0;
      wait_n(2);
   endtask

   task automatic press_units();
      @(negedge clk) units_btn = 1'b1;
      wait_n(2);
      units_btn = 1'b0;
      wait_n(2);
   endtask

   // From a freshly entered idle phase through the whole burst
   task automatic start_ping(input bit noisy);
      repeat (IDLE - 1) tick_foot();
      chk("R4 idle interval not yet over", 32'(tx_en), 0);
      chk("R10 display held in idle", 32'(seg_n), 32'(cur_disp));
      tick_foot();
      chk("R4 burst starts after interval", 32'(tx_en), 1);
      for (int i = 0; i < BURST - 1; i++) begin
         if (noisy && i == 1) echo_in = 1'b1;
         if (noisy && i == 4) echo_in = 1'b0;
         tick_car();
      end
      chk("R5 R8 burst still on before last pulse", 32'(tx_en), 1);
      chk("R8 display untouched in send", 32'(seg_n), 32'(cur_disp));
      tick_car();
      chk("R5 burst ends on last pulse", 32'(tx_en), 0);
   endtask

   task automatic echo_check(input string req, input logic [20:0] exp);
      @(negedge clk) echo_in = 1'b1;
      wait_n(5);
      echo_in = 1'b0;
      wait_n(4);
      chk(req, 32'(seg_n), 32'(exp));
      chk("R9 no error after good echo", 32'(err), 0);
      cur_disp = exp;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);
      // R1 reset state
      chk("R1 tx off", 32'(tx_en), 0);
      chk("R1 segments dark", 32'(seg_n), 32'h1FFFFF);
      chk("R1 unit LEDs dark", 32'({led_feet_n, led_meters_n}), 3);
      chk("R1 error low", 32'(err), 0);
      press_units();
      chk("R1 units ignored while off", 32'({led_feet_n, led_meters_n}), 3);
      // R2 power up
      press_pwr();
      chk("R2 R3 power up in feet", 32'({led_feet_n, led_meters_n}), 1);
      chk("R2 power up shows 000", 32'(seg_n), 32'(disp(0)));
      cur_disp = disp(0);

      // Table of pings
      for (int v = 0; v < NV; v++) begin
         if (VEC[v][0] != int'(cur_m)) begin
            press_units();
            cur_m = ~cur_m;
            chk("R3 units toggles LEDs", 32'({led_feet_n, led_meters_n}),
                cur_m ? 2 : 1);
         end
         start_ping(v == 0);
         repeat (VEC[v][1]) tick_foot();
         echo_check(cur_m ? "R7 meters reading" : "R6 feet reading", disp(VEC[v][2]));
      end

      // R11 saturation (feet mode)
      start_ping(1'b0);
      repeat (1002) tick_foot();
      echo_check("R11 count saturates at 999", disp(999));

      // R9 timeout
      start_ping(1'b0);
      repeat (RXT - 1) tick_foot();
      chk("R9 no error before window ends", 32'(err), 0);
      chk("R9 display held before window ends", 32'(seg_n), 32'(cur_disp));
      tick_foot();
      chk("R9 error raised on timeout", 32'(err), 1);
      chk("R9 dashes on timeout", 32'(seg_n), 32'(DASHES));
      cur_disp = DASHES;
      start_ping(1'b0);
      repeat (7) tick_foot();
      echo_check("R9 reading after error clears", disp(7));

      // R3 units in idle, then power off in receive
      press_units();
      cur_m = 1'b1;
      chk("R3 meters LED in idle", 32'({led_feet_n, led_meters_n}), 2);
      chk("R3 units does not start burst", 32'(tx_en), 0);
      start_ping(1'b0);
      repeat (5) tick_foot();
      press_pwr();
      chk("R2 power off from receive", 32'({tx_en, led_feet_n, led_meters_n, err}), 6);
      chk("R2 segments dark when off", 32'(seg_n), 32'h1FFFFF);
      press_units();
      press_pwr();
      chk("R3 mode kept across power off", 32'({led_feet_n, led_meters_n}), 2);
      chk("R2 power up shows 000 again", 32'(seg_n), 32'(disp(0)));
      cur_disp = disp(0);
      start_ping(1'b0);
      repeat (10) tick_foot();
      echo_check("R7 meters after power cycle", disp(3));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule